// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block holds a free-running 16-bit timer and two capture/compare channels. Each channel owns one 16-bit value register. In capture mode the register takes a snapshot of the timer when the channel's input shows the selected edge. In compare mode the channel raises a flag when the timer reaches the stored value. Software reads and writes the register as two separate bytes through a small byte-wide register port. A 2-bit mode field in a per-channel control register selects the behaviour.

The two channels are the same logic. One of them, chosen by a parameter, also drives a special event trigger on a compare match. That trigger clears the shared timer in the following cycle. A channel with the trigger therefore produces a periodic timebase whose period is the stored value plus one.

Top module: `capcmp_unit`

## Requirements
- R1: After reset, every channel is in the disabled mode, every value register and flag reads zero, `trig_o` is low and the timer reads zero.
- R2: The address is `{channel, sel[1:0]}`. Sel 0 is the low byte of the value register and sel 1 is the high byte. A write to one byte leaves the other byte and the other channel unchanged.
- R3: Sel 2 is the control register, with the mode in bits [1:0]: 0 disabled, 1 capture on rising edge, 2 capture on falling edge, 3 compare. The control register reads back the mode in bits [1:0] and zeros above. Sel 3 reads zero.
- R4: In a capture mode, the selected edge first seen at a clock edge loads the value register with the timer value held before that clock edge. The channel flag reads one from the next cycle on.
- R5: In a capture mode, the opposite edge changes neither the value register nor the flag.
- R6: In compare mode without the trigger, the flag reads one in the cycle after the timer equals the value register. `trig_o` stays low and the timer keeps counting.
- R7: On the trigger channel in compare mode, `trig_o` is high in the cycle the timer equals the value register, and the timer reads zero in the next cycle. The flag then reads one.
- R8: With the trigger running, successive `trig_o` pulses are exactly value+1 cycles apart.
- R9: Any write to a channel's control register clears that channel's flag. The clear wins over a capture or match in the same cycle.
- R10: In the disabled mode, input edges do not alter the value register or the flag.
- R11: Whenever no trigger is active, the timer increases by one each cycle and wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address {channel, sel} |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte (combinational from addr_i) |
| cap_i | input | 2 | Per-channel capture inputs |
| timer_o | output | 16 | Current timer value |
| flag_o | output | 2 | Per-channel sticky event flags |
| trig_o | output | 1 | Special event trigger pulse |

## Verification
Register writes take effect at the clock edge inside the write strobe, and reads are combinational. The bench therefore samples a written value at the falling edge that follows the strobe. A capture sets the register and the flag one rising edge after the input changes, and the expected value is the timer as sampled when the input was driven. A compare flag is due one cycle after the cycle in which `timer_o` equals the register. On the trigger channel, `trig_o` is checked in that same cycle and the zeroed timer one cycle later. The bench waits on the port values at falling edges, with bounded loops, and only then pushes the expectation into the scoreboard.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_CAP_RISE = 2'd1,
    MODE_CAP_FALL = 2'd2,
    MODE_CMP      = 2'd3
  } mode_e;

  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R11
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/capcmp_edge.sv
module capcmp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
  import capcmp_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter bit TRIG_EN = 1'b0,
  localparam int REG_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic              ctrl_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              cap_i,
  input  logic [REG_W-1:0]  timer_i,
  output logic [REG_W-1:0]  val_o,
  output mode_e             mode_o,
  output logic              flag_o,
  output logic              trig_o
);
  logic [REG_W-1:0] val_q;
  mode_e            mode_q;
  logic             flag_q;
  logic             rise, fall, cap_evt, match;

  capcmp_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (cap_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign cap_evt = (mode_q == MODE_CAP_RISE && rise) ||
                   (mode_q == MODE_CAP_FALL && fall);
  assign match   = (mode_q == MODE_CMP) && (timer_i == val_q);

  if (TRIG_EN) begin : g_trig
    assign trig_o = match;
  end else begin : g_no_trig
    assign trig_o = 1'b0;
  end

  // capture has priority over a same-cycle byte write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (cap_evt) begin
      val_q <= timer_i;
    end else begin
      if (lo_wr_i) val_q[BYTE_W-1:0]     <= wdata_i;
      if (hi_wr_i) val_q[REG_W-1:BYTE_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_OFF;
    else if (ctrl_wr_i) mode_q <= mode_e'(wdata_i[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (ctrl_wr_i)         flag_q <= 1'b0;
    else if (cap_evt || match)  flag_q <= 1'b1;
  end

  assign val_o  = val_q;
  assign mode_o = mode_q;
  assign flag_o = flag_q;

  // R4
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt && !ctrl_wr_i |=> val_q == $past(timer_i) && flag_q);
  // R6
  cmp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match && !ctrl_wr_i |=> flag_q);
  // R9
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> !flag_q);
  // R10
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_OFF && !lo_wr_i && !hi_wr_i && !ctrl_wr_i && !flag_q
    |=> $stable(val_q) && !flag_q);
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
  import capcmp_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int TRIG_CH = 0,
  parameter int BYTE_W  = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 2,
  localparam int REG_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] cap_i,
  output logic [REG_W-1:0]  timer_o,
  output logic [NUM_CH-1:0] flag_o,
  output logic              trig_o
);
  logic [CH_W-1:0]  ch_sel;
  logic [1:0]       sel;
  logic [REG_W-1:0] timer;
  logic [REG_W-1:0] val_v  [NUM_CH];
  mode_e            mode_v [NUM_CH];
  logic [NUM_CH-1:0] trig_v;

  assign ch_sel = addr_i[ADDR_W-1:2];
  assign sel    = addr_i[1:0];

  capcmp_timer #(.W(REG_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (trig_o),
    .cnt_o  (timer)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en_i && (ch_sel == CH_W'(i));

    capcmp_channel #(
      .BYTE_W  (BYTE_W),
      .TRIG_EN (i == TRIG_CH)
    ) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lo_wr_i   (hit && sel == SEL_LO),
      .hi_wr_i   (hit && sel == SEL_HI),
      .ctrl_wr_i (hit && sel == SEL_CTRL),
      .wdata_i   (wdata_i),
      .cap_i     (cap_i[i]),
      .timer_i   (timer),
      .val_o     (val_v[i]),
      .mode_o    (mode_v[i]),
      .flag_o    (flag_o[i]),
      .trig_o    (trig_v[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel == CH_W'(i)) begin
        case (sel)
          SEL_LO:   rdata_o = val_v[i][BYTE_W-1:0];
          SEL_HI:   rdata_o = val_v[i][REG_W-1:BYTE_W];
          SEL_CTRL: rdata_o = BYTE_W'(mode_v[i]);
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  assign trig_o  = |trig_v;
  assign timer_o = timer;

  // R7
  trig_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> timer_o == '0);
endmodule

// File: tb/test_capcmp_unit.sv
module test_capcmp_unit;
  logic        clk, rst_n, wr_en, trig;
  logic [2:0]  addr;
  logic [7:0]  wdata, rdata;
  logic [1:0]  cap, flag;
  logic [15:0] timer;

  int n_cmp = 0, n_bad = 0;
  string req_q[$];
  int    exp_q[$];

  capcmp_unit i_capcmp_unit (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .cap_i (cap), .timer_o (timer),
    .flag_o (flag), .trig_o (trig)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // driver side: expected item into the scoreboard
  task automatic push(string r, int e);
    req_q.push_back(r);
    exp_q.push_back(e);
  endtask

  // monitor side: pop and compare against observed port value
  task automatic observe(int act);
    string r;
    int e;
    r = req_q.pop_front();
    e = exp_q.pop_front();
    n_cmp++;
    if (act != e) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, e);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic rd16(int ch, output int v);
    int lo, hi;
    rd(3'(ch * 4), lo);
    rd(3'(ch * 4 + 1), hi);
    v = (hi << 8) | lo;
  endtask

  task automatic wr16(int ch, logic [15:0] v);
    wr(3'(ch * 4), v[7:0]);
    wr(3'(ch * 4 + 1), v[15:8]);
  endtask

  task automatic wait_timer(logic [15:0] t);
    for (int k = 0; k < 1000 && timer != t; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v, t0, n;
    logic [15:0] tcap, nval;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; cap = '0;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); push("R1 reg", 0); observe(v);
    end
    push("R1 timer", 0); observe(int'(timer));
    push("R1 flag", 0);  observe(int'(flag));
    push("R1 trig", 0);  observe(int'(trig));
    rst_n = 1'b1;

    // R11 free-running count
    @(negedge clk);
    t0 = int'(timer);
    repeat (5) @(negedge clk);
    push("R11 count", t0 + 5); observe(int'(timer));

    // R2 byte access
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd16(0, v); push("R2 ch0 both", 16'h1234); observe(v);
    wr(3'd0, 8'hAB);
    rd16(0, v); push("R2 lo only", 16'h12AB); observe(v);
    wr(3'd5, 8'h77);
    rd16(1, v); push("R2 ch1 hi", 16'h7700); observe(v);
    rd16(0, v); push("R2 ch0 kept", 16'h12AB); observe(v);

    // R3 control and reserved
    wr(3'd6, 8'd1);
    rd(3'd6, v); push("R3 mode rb", 1); observe(v);
    rd(3'd3, v); push("R3 sel3", 0); observe(v);

    // R4 capture on rising edge, ch1
    tcap = timer; cap[1] = 1'b1;
    @(negedge clk);
    push("R4 rise flag", 1); observe(int'(flag[1]));
    rd16(1, v); push("R4 rise val", int'(tcap)); observe(v);

    // R9 control write clears flag
    wr(3'd6, 8'd1);
    push("R9 flag clr", 0); observe(int'(flag[1]));

    // R5 falling edge ignored in rising mode
    cap[1] = 1'b0;
    repeat (2) @(negedge clk);
    push("R5 flag", 0); observe(int'(flag[1]));
    rd16(1, v); push("R5 val", int'(tcap)); observe(v);

    // R4/R5 falling mode
    wr(3'd6, 8'd2);
    cap[1] = 1'b1;
    repeat (2) @(negedge clk);
    push("R5 rise ign", 0); observe(int'(flag[1]));
    tcap = timer; cap[1] = 1'b0;
    @(negedge clk);
    push("R4 fall flag", 1); observe(int'(flag[1]));
    rd16(1, v); push("R4 fall val", int'(tcap)); observe(v);

    // R10 disabled mode ignores edges
    wr(3'd6, 8'd0);
    cap[1] = 1'b1; repeat (2) @(negedge clk);
    cap[1] = 1'b0; repeat (2) @(negedge clk);
    push("R10 flag", 0); observe(int'(flag[1]));
    rd16(1, v); push("R10 val", int'(tcap)); observe(v);

    // R6 compare without trigger, ch1
    nval = timer + 16'd40;
    wr16(1, nval);
    wr(3'd6, 8'd3);
    wait_timer(nval);
    push("R6 at match", int'(nval)); observe(int'(timer));
    push("R6 no trig", 0); observe(int'(trig));
    push("R6 flag pre", 0); observe(int'(flag[1]));
    @(negedge clk);
    push("R6 flag", 1); observe(int'(flag[1]));
    push("R6 timer runs", int'(nval) + 1); observe(int'(timer));
    wr(3'd6, 8'd0);

    // R7 trigger channel ch0
    nval = timer + 16'd30;
    wr16(0, nval);
    wr(3'd2, 8'd3);
    wait_timer(nval);
    push("R7 trig", 1); observe(int'(trig));
    push("R7 flag pre", 0); observe(int'(flag[0]));
    @(negedge clk);
    push("R7 timer zero", 0); observe(int'(timer));
    push("R7 flag", 1); observe(int'(flag[0]));

    // R8 trigger period = value + 1
    n = 1;
    while (!trig && n < 1000) begin
      @(negedge clk);
      n++;
    end
    push("R8 period", int'(nval) + 1); observe(n);
    push("R8 timer at trig", int'(nval)); observe(int'(timer));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule